// File: doc/BRIEF.md
# Double-Buffered Two-Channel DAC Update Controller

This block receives 24-bit write frames over a serial link and keeps two codes for each of two DAC channels: a staged input code and a live output code. Frames are shifted in most significant bit first, a bit being taken on each falling edge of the serial clock while the frame select line is low. A complete frame is decoded into a command, a channel address and a 16-bit payload. Writes land in the staged input codes. The live output codes move only when the block decides that a channel should update.

A channel updates from one of four triggers: a falling edge on the active-low load pin, an explicit update command, the end of a write frame while the load pin is low, or the end of a write frame when that channel's bypass mask bit is set. A channel with its bypass bit set ignores the load pin. Every channel carries a pending flag that is set when its input code is written and cleared when its output code is refreshed. No trigger refreshes a channel whose flag is clear. Each channel also holds a 2-bit power mode that a dedicated command sets. The serial lines and the load pin are all resynchronised to the system clock, which must run well above the serial clock.

Top module: `dbuf_dac_ctrl`

## Requirements
- R1: A frame is 24 bits. Bits are sampled MSB first on falling serial clock edges while `frame_sel_n_i` is low. The frame fields are: bits 23:22 ignored, bits 21:19 command, bits 18:16 address, bits 15:0 payload.
- R2: A frame is discarded, changing no state, if `frame_sel_n_i` rises before 24 bits have arrived. Serial clock edges after the 24th bit are ignored until select rises.
- R3: Command 000 writes the payload into the input code of the addressed channel. Address 000 is A, 001 is B and 111 is both; any other address is ignored. The output code does not change while the load pin is high and the channel's mask bit is 0.
- R4: A falling edge of `load_n_i` copies the input code into the output code of every unmasked channel that has been written since its last update. One edge gives one transfer.
- R5: A channel that has not been written since its last update keeps its output code under any trigger.
- R6: While `load_n_i` is low, a frame that writes a channel's input code also updates that channel's output code at frame end.
- R7: Command 110 loads the bypass mask from payload bits 1:0 (bit 0 is A, bit 1 is B). The mask resets to 0. A masked channel updates at the end of every frame that writes it and ignores the load pin.
- R8: Command 001 updates the addressed pending channels. Command 011 writes and then updates the addressed channels within the same frame.
- R9: Command 100 sets the power mode from payload bits 5:4 for each channel selected by a 1 in payload bits 1:0 (bit 0 is A, bit 1 is B). Channels that are not selected keep their mode.
- R10: Commands 010, 101 and 111 change no state.
- R11: After reset the output codes, input codes, power modes, pending flags and mask are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial clock; data taken on its falling edge |
| frame_sel_n_i | input | 1 | Active-low frame select |
| ser_data_i | input | 1 | Serial data, MSB first |
| load_n_i | input | 1 | Active-low load strobe |
| dac_a_o | output | 16 | Live code of channel A |
| dac_b_o | output | 16 | Live code of channel B |
| pd_a_o | output | 2 | Power mode of channel A |
| pd_b_o | output | 2 | Power mode of channel B |

## Verification
The update path is driven with writes to one channel, to the other and to both, each followed by a load pulse. This separates the staging of writes from the transfer of codes, and shows that a load pulse leaves a channel alone when it was not written. The same writes are repeated with the load pin held low, with a channel masked, and through the explicit update and write-and-update commands, so that each trigger is seen to act alone. Truncated frames, overlong frames, illegal addresses and unused commands are each followed by a load pulse to show that they left no pending write behind. Payloads with asymmetric bit patterns confirm the MSB-first field positions.

// File: rtl/dbuf_pkg.sv
package dbuf_pkg;
    localparam int FRAME_BITS = 24;
    localparam int CODE_W     = 16;
    localparam int NCH        = 2;
    localparam int PD_W       = 2;
    localparam int PD_LSB     = 4;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);

    localparam logic [2:0] CMD_WR_IN  = 3'b000;
    localparam logic [2:0] CMD_UPD    = 3'b001;
    localparam logic [2:0] CMD_WR_UPD = 3'b011;
    localparam logic [2:0] CMD_PWR    = 3'b100;
    localparam logic [2:0] CMD_MASK   = 3'b110;
    localparam logic [2:0] ADDR_ALL   = 3'b111;

    typedef struct packed {
        logic [1:0]        pad;
        logic [2:0]        cmd;
        logic [2:0]        addr;
        logic [CODE_W-1:0] data;
    } frame_t;

    function automatic logic addr_hits(input logic [2:0] addr, input int ch);
        return (addr == ADDR_ALL) || (addr == 3'(ch));
    endfunction
endpackage

// File: rtl/dbuf_sync.sv
module dbuf_sync #(
    parameter int           W       = 1,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst) sr <= {STAGES{RST_VAL}};
        else     sr <= {sr[STAGES-2:0], d};
    end

    assign q = sr[STAGES-1];
endmodule

// File: rtl/dbuf_rx.sv
module dbuf_rx
    import dbuf_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   sck,
    input  logic   sel_n,
    input  logic   sdi,
    output logic   frame_vld,
    output frame_t frame
);
    logic                  sck_q;
    logic [CNT_W-1:0]      cnt;
    logic [FRAME_BITS-1:0] shreg;
    logic                  sck_fall;

    assign sck_fall = sck_q & ~sck;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q     <= 1'b0;
            cnt       <= '0;
            shreg     <= '0;
            frame_vld <= 1'b0;
        end else begin
            sck_q     <= sck;
            frame_vld <= 1'b0;
            if (sel_n) begin
                cnt <= '0;
            end else if (sck_fall && cnt != CNT_W'(FRAME_BITS)) begin
                shreg <= {shreg[FRAME_BITS-2:0], sdi};
                cnt   <= cnt + 1'b1;
                if (cnt == CNT_W'(FRAME_BITS - 1)) frame_vld <= 1'b1;
            end
        end
    end

    assign frame = frame_t'(shreg);
endmodule

// File: rtl/dbuf_chan.sv
module dbuf_chan
    import dbuf_pkg::*;
#(
    parameter int CH = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_vld,
    input  frame_t            frame,
    input  logic              load_lo,
    input  logic              load_fall,
    input  logic              mask_bit,
    output logic [CODE_W-1:0] dac,
    output logic [PD_W-1:0]   pd,
    output logic              dirty
);
    logic [CODE_W-1:0] in_q, in_nxt;
    logic sel, wr, upd_cmd, pwr, dirty_nxt, trig, xfer;

    always_comb begin
        sel       = frame_vld && addr_hits(frame.addr, CH);
        wr        = sel && (frame.cmd == CMD_WR_IN || frame.cmd == CMD_WR_UPD);
        upd_cmd   = sel && (frame.cmd == CMD_UPD || frame.cmd == CMD_WR_UPD);
        pwr       = frame_vld && frame.cmd == CMD_PWR && frame.data[CH];
        in_nxt    = wr ? frame.data : in_q;
        dirty_nxt = wr | dirty;
        trig      = upd_cmd | (wr & (mask_bit | load_lo)) | (load_fall & ~mask_bit);
        xfer      = trig & dirty_nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_q  <= '0;
            dac   <= '0;
            pd    <= '0;
            dirty <= 1'b0;
        end else begin
            in_q  <= in_nxt;
            dirty <= dirty_nxt & ~xfer;
            if (xfer) dac <= in_nxt;
            if (pwr)  pd  <= frame.data[PD_LSB +: PD_W];
        end
    end
endmodule

// File: rtl/dbuf_dac_ctrl.sv
module dbuf_dac_ctrl
    import dbuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_clk_i,
    input  logic              frame_sel_n_i,
    input  logic              ser_data_i,
    input  logic              load_n_i,
    output logic [CODE_W-1:0] dac_a_o,
    output logic [CODE_W-1:0] dac_b_o,
    output logic [PD_W-1:0]   pd_a_o,
    output logic [PD_W-1:0]   pd_b_o
);
    logic [3:0] pins_s;
    logic       sck_s, sel_n_s, sdi_s, load_n_s, load_q;
    logic       frame_vld, load_fall, load_lo;
    frame_t     frame;
    logic [NCH-1:0]             mask, dirty;
    logic [NCH-1:0][CODE_W-1:0] dac_w;
    logic [NCH-1:0][PD_W-1:0]   pd_w;

    dbuf_sync #(.W(4), .STAGES(2), .RST_VAL(4'b0101)) u_sync (
        .clk(clk), .rst(rst),
        .d({ser_clk_i, frame_sel_n_i, ser_data_i, load_n_i}),
        .q(pins_s)
    );
    assign {sck_s, sel_n_s, sdi_s, load_n_s} = pins_s;

    dbuf_rx u_rx (
        .clk(clk), .rst(rst), .sck(sck_s), .sel_n(sel_n_s), .sdi(sdi_s),
        .frame_vld(frame_vld), .frame(frame)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            load_q <= 1'b1;
            mask   <= '0;
        end else begin
            load_q <= load_n_s;
            if (frame_vld && frame.cmd == CMD_MASK) mask <= frame.data[NCH-1:0];
        end
    end

    assign load_fall = load_q & ~load_n_s;
    assign load_lo   = ~load_n_s;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        dbuf_chan #(.CH(c)) u_ch (
            .clk(clk), .rst(rst), .frame_vld(frame_vld), .frame(frame),
            .load_lo(load_lo), .load_fall(load_fall), .mask_bit(mask[c]),
            .dac(dac_w[c]), .pd(pd_w[c]), .dirty(dirty[c])
        );
    end

    assign dac_a_o = dac_w[0];
    assign dac_b_o = dac_w[1];
    assign pd_a_o  = pd_w[0];
    assign pd_b_o  = pd_w[1];
endmodule

// File: rtl/dbuf_dac_ctrl_chk.sv
module dbuf_dac_ctrl_chk
    import dbuf_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              frame_vld,
    input logic              load_fall,
    input logic [NCH-1:0]    mask,
    input logic [NCH-1:0]    dirty,
    input logic [CODE_W-1:0] dac_a_o,
    input logic [CODE_W-1:0] dac_b_o,
    input logic [PD_W-1:0]   pd_a_o,
    input logic [PD_W-1:0]   pd_b_o
);
    a_r11_reset_clear: assert property (@(posedge clk)
        rst |=> (dac_a_o == '0 && dac_b_o == '0 && pd_a_o == '0 && pd_b_o == '0 && mask == '0 && dirty == '0));

    a_r3_a_holds: assert property (@(posedge clk) disable iff (rst)
        (!frame_vld && !load_fall) |=> $stable(dac_a_o));

    a_r3_b_holds: assert property (@(posedge clk) disable iff (rst)
        (!frame_vld && !load_fall) |=> $stable(dac_b_o));

    a_r5_a_clean_holds: assert property (@(posedge clk) disable iff (rst)
        (!dirty[0] && !frame_vld) |=> $stable(dac_a_o));

    a_r4_update_clears_pending: assert property (@(posedge clk) disable iff (rst)
        !$stable(dac_b_o) |-> !dirty[1]);

    a_r7_mask_stable: assert property (@(posedge clk) disable iff (rst)
        !frame_vld |=> $stable(mask));

    a_r9_pd_stable: assert property (@(posedge clk) disable iff (rst)
        !frame_vld |=> ($stable(pd_a_o) && $stable(pd_b_o)));

    a_r1_single_frame_pulse: assert property (@(posedge clk) disable iff (rst)
        frame_vld |=> !frame_vld);
endmodule

bind dbuf_dac_ctrl dbuf_dac_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .frame_vld(frame_vld), .load_fall(load_fall),
    .mask(mask), .dirty(dirty), .dac_a_o(dac_a_o), .dac_b_o(dac_b_o),
    .pd_a_o(pd_a_o), .pd_b_o(pd_b_o)
);

// File: tb/dbuf_dac_ctrl_tb.sv
module dbuf_dac_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ser_clk = 1'b0;
    logic        sel_n = 1'b1;
    logic        sdata = 1'b0;
    logic        load_n = 1'b1;
    logic [15:0] dac_a, dac_b;
    logic [1:0]  pd_a, pd_b;
    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dbuf_dac_ctrl u_dut (
        .clk(clk), .rst(rst), .ser_clk_i(ser_clk), .frame_sel_n_i(sel_n),
        .ser_data_i(sdata), .load_n_i(load_n),
        .dac_a_o(dac_a), .dac_b_o(dac_b), .pd_a_o(pd_a), .pd_b_o(pd_b)
    );

    function automatic logic [23:0] mk(input logic [2:0] cmd, input logic [2:0] addr,
                                       input logic [15:0] data);
        return {2'b00, cmd, addr, data};
    endfunction

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_all(input string tag, input logic [15:0] ea, input logic [15:0] eb);
        chk({tag, " dac_a"}, dac_a, ea);
        chk({tag, " dac_b"}, dac_b, eb);
    endtask

    // Sends the first nbits of a 24-bit word plus extra trailing clocks.
    task automatic send(input logic [23:0] w, input int nbits, input int extra);
        @(negedge clk);
        sel_n = 1'b0;
        wait_n(4);
        for (int i = 0; i < nbits + extra; i++) begin
            ser_clk = 1'b1;
            sdata = (i < nbits) ? w[23 - i] : 1'b1;
            wait_n(4);
            ser_clk = 1'b0;
            wait_n(4);
        end
        sel_n = 1'b1;
        wait_n(10);
    endtask

    task automatic frame(input logic [2:0] cmd, input logic [2:0] addr, input logic [15:0] data);
        send(mk(cmd, addr, data), 24, 0);
    endtask

    task automatic load_pulse();
        load_n = 1'b0;
        wait_n(8);
        load_n = 1'b1;
        wait_n(8);
    endtask

    task automatic t_reset();
        chk_all("R11 reset", 16'h0000, 16'h0000);
        chk("R11 reset pd", {12'd0, pd_a, pd_b}, 16'h0000);
    endtask

    task automatic t_stage_and_load();
        frame(3'b000, 3'b000, 16'h8001);
        chk_all("R3 write A staged", 16'h0000, 16'h0000);
        frame(3'b000, 3'b001, 16'h5678);
        chk_all("R3 write B staged", 16'h0000, 16'h0000);
        load_pulse();
        chk_all("R4 R1 load transfers both", 16'h8001, 16'h5678);
    endtask

    task automatic t_clean_kept();
        frame(3'b000, 3'b000, 16'hAAAA);
        load_pulse();
        chk_all("R5 only written channel moves", 16'hAAAA, 16'h5678);
        load_pulse();
        chk_all("R5 second pulse no change", 16'hAAAA, 16'h5678);
    endtask

    task automatic t_commands();
        frame(3'b000, 3'b000, 16'h1111);
        frame(3'b001, 3'b000, 16'h0000);
        chk_all("R8 update command", 16'h1111, 16'h5678);
        frame(3'b011, 3'b111, 16'h2222);
        chk_all("R8 R3 write-update both", 16'h2222, 16'h2222);
        frame(3'b011, 3'b011, 16'h9999);
        load_pulse();
        chk_all("R3 illegal address ignored", 16'h2222, 16'h2222);
    endtask

    task automatic t_mask();
        frame(3'b110, 3'b000, 16'h0002);
        frame(3'b000, 3'b111, 16'h3333);
        chk_all("R7 masked B updates at frame end", 16'h2222, 16'h3333);
        load_pulse();
        chk_all("R7 load pulse moves unmasked A", 16'h3333, 16'h3333);
        frame(3'b000, 3'b001, 16'h4444);
        chk_all("R7 masked B direct", 16'h3333, 16'h4444);
        frame(3'b110, 3'b000, 16'h0000);
        frame(3'b000, 3'b001, 16'h4545);
        chk_all("R7 mask cleared B staged", 16'h3333, 16'h4444);
        load_pulse();
        chk_all("R7 mask cleared B on load", 16'h3333, 16'h4545);
    endtask

    task automatic t_load_low();
        load_n = 1'b0;
        wait_n(8);
        frame(3'b000, 3'b000, 16'h6666);
        chk_all("R6 load low transparent", 16'h6666, 16'h4545);
        load_n = 1'b1;
        wait_n(8);
    endtask

    task automatic t_framing();
        send(mk(3'b011, 3'b111, 16'h7777), 12, 0);
        chk_all("R2 short frame dropped", 16'h6666, 16'h4545);
        load_pulse();
        chk_all("R2 short frame left nothing pending", 16'h6666, 16'h4545);
        send({2'b11, 3'b011, 3'b000, 16'h0ABC}, 24, 2);
        chk_all("R2 R1 long frame keeps first 24 bits", 16'h0ABC, 16'h4545);
    endtask

    task automatic t_power();
        frame(3'b100, 3'b000, 16'h0021);
        chk("R9 pd A set", {14'd0, pd_a}, 16'd2);
        chk("R9 pd B untouched", {14'd0, pd_b}, 16'd0);
        frame(3'b100, 3'b000, 16'h0032);
        chk("R9 pd B set", {14'd0, pd_b}, 16'd3);
        chk("R9 pd A kept", {14'd0, pd_a}, 16'd2);
    endtask

    task automatic t_unused();
        frame(3'b010, 3'b111, 16'h1357);
        frame(3'b101, 3'b111, 16'h0033);
        frame(3'b111, 3'b111, 16'h0003);
        chk_all("R10 unused commands no output change", 16'h0ABC, 16'h4545);
        load_pulse();
        chk_all("R10 unused commands nothing pending", 16'h0ABC, 16'h4545);
        chk("R10 pd unchanged", {12'd0, pd_a, pd_b}, 16'h000B);
        frame(3'b000, 3'b001, 16'hBEEF);
        chk_all("R10 mask still clear", 16'h0ABC, 16'h4545);
    endtask

    initial begin
        wait_n(5);
        rst = 1'b0;
        wait_n(5);
        t_reset();
        t_stage_and_load();
        t_clean_kept();
        t_commands();
        t_mask();
        t_load_low();
        t_framing();
        t_power();
        t_unused();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        end
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        end
        $finish;
    end
endmodule